// File: doc/BRIEF.md
# Marker-Tagged Compressed Line Reader

This block sits on the read path of a memory controller whose 64-byte lines are split into two independently readable 32-byte sub-ranks. A line stored in compressed form begins with a 15-bit marker and a disambiguation bit, followed by its payload, all inside one sub-rank. No metadata cache is involved. For each request the block reads the sub-rank that could hold the marker and compares its leading bits with a marker register. It then does one of three things:

- hands the remaining bits to a decompressor as a compressed payload;
- fetches the other sub-rank and joins the two halves into a plain line;
- on a marker conflict, where the marker matches but the disambiguation bit is clear, reads a substitute bit from a side area, then the other half, and writes the substitute into the line.

The marker and the side-area base are loaded once after reset and then locked. Memory reads use a valid/ready request and a valid response, with at most one read in flight. Each result is presented for a single cycle, with a flag that tells a compressed payload apart from a full line.

Top module: `mlr_line_reader`

## Requirements
- R1: Before the first `cfg_load_i` after reset, `req_ready_o` is 0. The first load captures `cfg_marker_i` and `cfg_base_i`. Every later load until the next reset is ignored.
- R2: The probe read targets sub-rank `line[ROW_BIT]` (default bit 5): 0 selects the lower half (`mem_req_half_o`=0) and 1 selects the upper half. The other read targets the opposite half. Data reads use address = line index with `mem_req_side_o`=0.
- R3: If probed bits [14:0] differ from the marker, the block makes exactly two reads. The result is `out_comp_o`=0 with `out_data_o` = {other half, probed half}, where the probed half sits in bits [255:0].
- R4: If bits [14:0] equal the marker and bit 15 is 1, the block makes exactly one read. The result is `out_comp_o`=1 with `out_data_o` = probed bits [255:16], zero-extended.
- R5: If bits [14:0] equal the marker and bit 15 is 0, the block makes three reads in this order: probe, side, other. The side read has `mem_req_side_o`=1 at address base + (line >> 8), and the substitute bit is bit line[7:0] of the returned word.
- R6: On a conflict, the result is the R3 line with bit 15 replaced by the substitute bit, with `out_comp_o`=0.
- R7: At most one memory read is outstanding. No request is raised while a response is awaited.
- R8: `out_valid_o` is a one-cycle pulse, given once per accepted request. `req_ready_o` is high only while idle and configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load marker and base (first load only) |
| cfg_marker_i | input | 15 | Marker value to load |
| cfg_base_i | input | 32 | Side-area base address to load |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Ready for a request |
| req_line_i | input | 20 | Line index to read |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 32 | Memory read address |
| mem_req_half_o | output | 1 | Sub-rank select, 1 = upper |
| mem_req_side_o | output | 1 | Read targets the side area |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 256 | Read data |
| out_valid_o | output | 1 | Result valid, one cycle |
| out_comp_o | output | 1 | 1 = compressed payload, 0 = full line |
| out_data_o | output | 512 | Payload or assembled line |

## Verification
The bench aims at row-parity changes between neighbouring lines. A design that ignored parity would probe the wrong half and read the other half twice. It mixes conflict lines whose substitute bit is 0 and 1 and whose side words differ. A design that skipped the restore or used the wrong bit index would return the marker-area bit unchanged or take a bit from another line. Plain lines differ from the marker in a single low bit, which exposes a partial compare. The bench also tries to reload the marker and base after configuration. A design without the lock would then misclassify lines, or send side reads to the wrong base.

// File: rtl/mlr_pkg.sv
package mlr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROBE, ST_CHECK, ST_FETCH_BIT, ST_FETCH_OTHER, ST_DONE
  } mlr_state_e;

  typedef enum logic [1:0] {
    VD_PLAIN, VD_COMP, VD_CONFLICT
  } mlr_verdict_e;
endpackage

// File: rtl/mlr_cfg_regs.sv
module mlr_cfg_regs #(
  parameter int MARK_W = 15,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MARK_W-1:0] marker_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [MARK_W-1:0] marker_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              locked_o
);
  logic [MARK_W-1:0] marker_q;
  logic [ADDR_W-1:0] base_q;
  logic              locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      marker_q <= '0;
      base_q   <= '0;
      locked_q <= 1'b0;
    end else if (load_i && !locked_q) begin
      marker_q <= marker_i;
      base_q   <= base_i;
      locked_q <= 1'b1;
    end
  end

  assign marker_o = marker_q;
  assign base_o   = base_q;
  assign locked_o = locked_q;

  // R1
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q && $stable(marker_q) && $stable(base_q));
endmodule

// File: rtl/mlr_classify.sv
module mlr_classify
  import mlr_pkg::*;
#(
  parameter int MARK_W = 15
) (
  input  logic [MARK_W:0]   lead_i,
  input  logic [MARK_W-1:0] marker_i,
  output mlr_verdict_e      verdict_o
);
  logic hit;
  assign hit = (lead_i[MARK_W-1:0] == marker_i);

  always_comb begin
    if (!hit)              verdict_o = VD_PLAIN;
    else if (lead_i[MARK_W]) verdict_o = VD_COMP;
    else                   verdict_o = VD_CONFLICT;
  end
endmodule

// File: rtl/mlr_assemble.sv
module mlr_assemble #(
  parameter int HALF_W = 256,
  parameter int MARK_W = 15,
  localparam int LINE_W = 2 * HALF_W,
  localparam int PAY_W  = HALF_W - MARK_W - 1
) (
  input  logic [HALF_W-1:0] probe_i,
  input  logic [HALF_W-1:0] other_i,
  input  logic              comp_i,
  input  logic              conflict_i,
  input  logic              side_bit_i,
  output logic [LINE_W-1:0] data_o
);
  logic [HALF_W-1:0] first_half;

  // disambiguation bit restored from the side area on a conflict
  always_comb begin
    first_half = probe_i;
    if (conflict_i) first_half[MARK_W] = side_bit_i;
  end

  always_comb begin
    if (comp_i) data_o = {{(LINE_W-PAY_W){1'b0}}, probe_i[HALF_W-1:MARK_W+1]};
    else        data_o = {other_i, first_half};
  end
endmodule

// File: rtl/mlr_seq.sv
module mlr_seq
  import mlr_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         locked_i,
  input  logic         req_valid_i,
  input  mlr_verdict_e verdict_i,
  input  logic         mem_req_ready_i,
  input  logic         mem_rsp_valid_i,
  output logic         req_ready_o,
  output logic         req_fire_o,
  output logic         mem_req_valid_o,
  output logic         rsp_take_o,
  output logic         out_valid_o,
  output mlr_state_e   state_o
);
  mlr_state_e state_q, state_d;
  logic       sent_q, sent_d;
  logic       fetching;

  assign fetching        = (state_q == ST_PROBE) || (state_q == ST_FETCH_BIT) ||
                           (state_q == ST_FETCH_OTHER);
  assign mem_req_valid_o = fetching && !sent_q;
  assign rsp_take_o      = fetching && sent_q && mem_rsp_valid_i;
  assign req_ready_o     = (state_q == ST_IDLE) && locked_i;
  assign req_fire_o      = req_ready_o && req_valid_i;
  assign out_valid_o     = (state_q == ST_DONE);
  assign state_o         = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        if (req_fire_o) state_d = ST_PROBE;
      ST_PROBE:       if (rsp_take_o) state_d = ST_CHECK;
      ST_CHECK: begin
        unique case (verdict_i)
          VD_COMP:     state_d = ST_DONE;
          VD_CONFLICT: state_d = ST_FETCH_BIT;
          default:     state_d = ST_FETCH_OTHER;
        endcase
      end
      ST_FETCH_BIT:   if (rsp_take_o) state_d = ST_FETCH_OTHER;
      ST_FETCH_OTHER: if (rsp_take_o) state_d = ST_DONE;
      ST_DONE:        state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    sent_d = sent_q;
    if (state_d != state_q)                   sent_d = 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) sent_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_d;
    end
  end

  // R7
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  // R8
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o && req_ready_o == locked_i);
endmodule

// File: rtl/mlr_line_reader.sv
module mlr_line_reader
  import mlr_pkg::*;
#(
  parameter int HALF_W  = 256,
  parameter int MARK_W  = 15,
  parameter int ADDR_W  = 32,
  parameter int LIDX_W  = 20,
  parameter int ROW_BIT = 5,
  localparam int LINE_W  = 2 * HALF_W,
  localparam int SIDE_SH = $clog2(HALF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [MARK_W-1:0] cfg_marker_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LIDX_W-1:0] req_line_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_req_half_o,
  output logic              mem_req_side_o,
  input  logic              mem_rsp_valid_i,
  input  logic [HALF_W-1:0] mem_rsp_data_i,
  output logic              out_valid_o,
  output logic              out_comp_o,
  output logic [LINE_W-1:0] out_data_o
);
  logic [MARK_W-1:0] marker;
  logic [ADDR_W-1:0] base;
  logic              locked;
  logic              req_fire, rsp_take;
  mlr_state_e        st;
  mlr_verdict_e      verdict;

  logic [LIDX_W-1:0] line_q;
  logic [HALF_W-1:0] probe_q, other_q;
  logic              side_bit_q, comp_q, conflict_q, probe_half_q;
  logic              row_odd;

  mlr_cfg_regs #(.MARK_W(MARK_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .load_i(cfg_load_i), .marker_i(cfg_marker_i), .base_i(cfg_base_i),
    .marker_o(marker), .base_o(base), .locked_o(locked)
  );

  mlr_classify #(.MARK_W(MARK_W)) u_cls (
    .lead_i(probe_q[MARK_W:0]), .marker_i(marker), .verdict_o(verdict)
  );

  mlr_seq u_seq (
    .clk_i, .rst_ni,
    .locked_i(locked), .req_valid_i, .verdict_i(verdict),
    .mem_req_ready_i, .mem_rsp_valid_i,
    .req_ready_o, .req_fire_o(req_fire), .mem_req_valid_o,
    .rsp_take_o(rsp_take), .out_valid_o, .state_o(st)
  );

  mlr_assemble #(.HALF_W(HALF_W), .MARK_W(MARK_W)) u_asm (
    .probe_i(probe_q), .other_i(other_q), .comp_i(comp_q),
    .conflict_i(conflict_q), .side_bit_i(side_bit_q), .data_o(out_data_o)
  );

  assign row_odd = line_q[ROW_BIT];

  always_comb begin
    mem_req_side_o = (st == ST_FETCH_BIT);
    mem_req_half_o = (st == ST_FETCH_OTHER) ? ~row_odd : row_odd;
    if (mem_req_side_o) mem_req_addr_o = base + ADDR_W'(line_q >> SIDE_SH);
    else                mem_req_addr_o = ADDR_W'(line_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q       <= '0;
      probe_q      <= '0;
      other_q      <= '0;
      side_bit_q   <= 1'b0;
      comp_q       <= 1'b0;
      conflict_q   <= 1'b0;
      probe_half_q <= 1'b0;
    end else begin
      if (req_fire) begin
        line_q     <= req_line_i;
        comp_q     <= 1'b0;
        conflict_q <= 1'b0;
      end
      if (mem_req_valid_o && mem_req_ready_i && st == ST_PROBE)
        probe_half_q <= mem_req_half_o;
      if (rsp_take && st == ST_PROBE)       probe_q    <= mem_rsp_data_i;
      if (rsp_take && st == ST_FETCH_BIT)   side_bit_q <= mem_rsp_data_i[line_q[SIDE_SH-1:0]];
      if (rsp_take && st == ST_FETCH_OTHER) other_q    <= mem_rsp_data_i;
      if (st == ST_CHECK) begin
        comp_q     <= (verdict == VD_COMP);
        conflict_q <= (verdict == VD_CONFLICT);
      end
    end
  end

  assign out_comp_o = comp_q;

  // R2
  other_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && st == ST_FETCH_OTHER) |-> mem_req_half_o != probe_half_q);

  // R5
  side_only_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_side_o) |-> conflict_q);

  // R4
  comp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CHECK && verdict == VD_COMP) |=> out_valid_o && out_comp_o);
endmodule

// File: tb/mlr_line_reader_tb_top.sv
module mlr_line_reader_tb_top;
  localparam int HALF_W = 256;
  localparam int LINE_W = 512;
  localparam int NLINES = 512;
  localparam logic [31:0] BASE  = 32'h0004_0000;
  localparam logic [14:0] MARK  = 15'h5A3C;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic              cfg_load = 1'b0;
  logic [14:0]       cfg_marker = '0;
  logic [31:0]       cfg_base = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [19:0]       req_line = '0;
  logic              mreq_valid, mreq_ready = 1'b0, mreq_half, mreq_side;
  logic [31:0]       mreq_addr;
  logic              mrsp_valid = 1'b0;
  logic [HALF_W-1:0] mrsp_data = '0;
  logic              out_valid, out_comp;
  logic [LINE_W-1:0] out_data;

  mlr_line_reader dut_i (
    .clk_i(clk), .rst_ni,
    .cfg_load_i(cfg_load), .cfg_marker_i(cfg_marker), .cfg_base_i(cfg_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_line_i(req_line),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_addr_o(mreq_addr), .mem_req_half_o(mreq_half), .mem_req_side_o(mreq_side),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data),
    .out_valid_o(out_valid), .out_comp_o(out_comp), .out_data_o(out_data)
  );

  logic [HALF_W-1:0] mem_lo [NLINES];
  logic [HALF_W-1:0] mem_hi [NLINES];
  logic [HALF_W-1:0] side_mem [2];

  int total = 0, bad = 0;
  bit done = 0;

  // request log filled by the memory model
  int          rd_cnt;
  logic        rd_half [4];
  logic        rd_side [4];
  logic [31:0] rd_addr [4];
  bit          overlap_err;

  task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [HALF_W-1:0] rnd_half();
    logic [HALF_W-1:0] v;
    for (int i = 0; i < HALF_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // kind: 0 plain, 1 compressed, 2 conflict
  task automatic make_line(input int idx, input int kind, input bit sbit);
    logic [HALF_W-1:0] p;
    p = rnd_half();
    if (kind == 0) begin
      p[14:0] = MARK ^ (15'h1 << ($urandom % 15));
    end else begin
      p[14:0] = MARK;
      p[15]   = (kind == 1);
    end
    side_mem[idx >> 8][idx % 256] = sbit;
    if (idx[5]) begin mem_hi[idx] = p; mem_lo[idx] = rnd_half(); end
    else        begin mem_lo[idx] = p; mem_hi[idx] = rnd_half(); end
  endtask

  function automatic logic [LINE_W-1:0] exp_data(input int idx);
    logic [HALF_W-1:0] p, o;
    p = idx[5] ? mem_hi[idx] : mem_lo[idx];
    o = idx[5] ? mem_lo[idx] : mem_hi[idx];
    if (p[14:0] == MARK && p[15]) return LINE_W'(p[HALF_W-1:16]);
    if (p[14:0] == MARK) p[15] = side_mem[idx >> 8][idx % 256];
    return {o, p};
  endfunction

  function automatic int exp_kind(input int idx);
    logic [HALF_W-1:0] p;
    p = idx[5] ? mem_hi[idx] : mem_lo[idx];
    if (p[14:0] != MARK) return 0;
    return p[15] ? 1 : 2;
  endfunction

  // memory model
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [HALF_W-1:0] pdata;
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin mrsp_valid = 1'b1; mrsp_data = pdata; pend = 0; end
        else cnt--;
        if (mreq_valid) overlap_err = 1;
      end
      mreq_ready = !pend && ($urandom % 4 != 0);
      if (mreq_valid && mreq_ready) begin
        if (rd_cnt < 4) begin
          rd_half[rd_cnt] = mreq_half;
          rd_side[rd_cnt] = mreq_side;
          rd_addr[rd_cnt] = mreq_addr;
        end
        rd_cnt++;
        if (mreq_side)
          pdata = (mreq_addr - BASE < 2) ? side_mem[mreq_addr - BASE] : '0;
        else if (mreq_addr < NLINES)
          pdata = mreq_half ? mem_hi[mreq_addr] : mem_lo[mreq_addr];
        else pdata = '0;
        pend = 1;
        cnt = $urandom % 4;
      end
    end
  end

  task automatic do_read(input int idx);
    int k;
    bit ph;
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    overlap_err = 0;
    req_valid = 1'b1;
    req_line = 20'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    k = exp_kind(idx);
    ph = idx[5];
    chk(out_comp == (k == 1), "R3/R4 comp flag", LINE_W'(out_comp), LINE_W'(k == 1));
    chk(out_data == exp_data(idx), k == 2 ? "R6 conflict line" : (k == 1 ? "R4 payload" : "R3 line"),
        out_data, exp_data(idx));
    chk(rd_cnt == k + 1 + (k == 0 ? 1 : 0) - (k == 1 ? 1 : 0), "R3/R4/R5 read count",
        LINE_W'(rd_cnt), LINE_W'(k == 0 ? 2 : (k == 1 ? 1 : 3)));
    chk(rd_half[0] == ph && !rd_side[0] && rd_addr[0] == 32'(idx), "R2 probe half/addr",
        LINE_W'({rd_half[0], rd_side[0], rd_addr[0]}), LINE_W'({ph, 1'b0, 32'(idx)}));
    if (k == 2)
      chk(rd_side[1] && rd_addr[1] == BASE + 32'(idx >> 8), "R5 side read",
          LINE_W'({rd_side[1], rd_addr[1]}), LINE_W'({1'b1, BASE + 32'(idx >> 8)}));
    if (k != 1)
      chk(rd_half[rd_cnt-1] == !ph && !rd_side[rd_cnt-1], "R2 other half",
          LINE_W'(rd_half[rd_cnt-1]), LINE_W'(!ph));
    chk(!overlap_err, "R7 one outstanding", LINE_W'(overlap_err), '0);
    @(negedge clk);
    chk(!out_valid, "R8 pulse", LINE_W'(out_valid), '0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NLINES; i++) make_line(i, $urandom % 3, $urandom % 2);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!req_ready && !out_valid, "R1/R8 reset state", LINE_W'({req_ready, out_valid}), '0);
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_ready && rd_cnt == 0, "R1 unconfigured idle", LINE_W'(req_ready), '0);
    req_valid = 1'b0;
    cfg_load = 1'b1; cfg_marker = MARK; cfg_base = BASE;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(req_ready, "R1 ready after load", LINE_W'(req_ready), LINE_W'(1));
    // directed corners
    make_line(0, 0, 0);  do_read(0);
    make_line(1, 1, 0);  do_read(1);
    make_line(32, 1, 0); do_read(32);
    make_line(33, 0, 1); do_read(33);
    make_line(2, 2, 1);  do_read(2);
    make_line(3, 2, 0);  do_read(3);
    make_line(34, 2, 1); do_read(34);
    make_line(300, 2, 1); side_mem[1][299 % 256] = 1'b0; make_line(299, 2, 0);
    do_read(300); do_read(299);
    // later load must be ignored
    cfg_load = 1'b1; cfg_marker = ~MARK; cfg_base = 32'h0009_0000;
    @(negedge clk);
    cfg_load = 1'b0;
    make_line(4, 1, 0); do_read(4);
    make_line(5, 2, 1); do_read(5);
    make_line(6, 0, 0); mem_lo[6][15:0] = {1'b1, ~MARK}; do_read(6);
    for (int n = 0; n < 80; n++) do_read($urandom % NLINES);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule